// File: doc/BRIEF.md
# Switchable Supply Enable Controller

This block produces the on/off control and the output-voltage code for a small group of regulated supplies that feed front-end hybrids. Each channel has two comparator flags coming in from analog circuitry outside the block: an over-current flag and a latch-up flag. A per-channel register holds an enable bit and a setpoint code, and software loads it through a simple write port. Sticky status flags record every trip until software clears them.

A strap input fixes how the controller behaves. With the strap high, the controller runs in automatic mode. Every channel switches itself on after reset. A trip turns the channel off for a fixed hold-off window, then the channel comes back on and a per-channel retry counter counts the recovery. With the strap low, the controller runs in software mode. A channel is on only while its enable bit is set. A trip clears the enable bit, and the channel cannot be turned on again until its flags are cleared.

The setpoint code is 4 bits wide and maps linearly onto the regulator range: code 0 is 2.1 V, code 15 is 2.9 V, and each step is 0.8/15 V. The code is sent straight to the regulator.

Top module: `supply_enable_ctrl`

## Requirements
- R1: During reset and after reset is released, until the first clock edge, every pwr_en_o bit is 0, every vcode_o field is 8 (mid-scale), every flag bit is 0 and every retry_o field is 0.
- R2: In automatic mode (auto_mode_i=1), every channel turns on at the first clock edge after reset with no write. The enable bit carried by a write has no effect on pwr_en_o.
- R3: In automatic mode, a trip sampled at edge T drives that channel's pwr_en_o to 0 after edge T. The output stays 0 through edge T+HOLD-1 and returns to 1 after edge T+HOLD (HOLD defaults to 1024). At that edge the channel's retry field increments by 1.
- R4: In automatic mode, a trip that arrives inside the hold-off window restarts the full window from that trip, and the retry count rises by only one for the whole episode. The retry field saturates at 15.
- R5: In software mode, a write sets channel wr_ch_i's pwr_en_o to wr_en_i at the next edge. No other channel's enable changes.
- R6: In software mode, a trip (oc_i or lu_i bit high) clears that channel's enable at the next edge. The channel stays off.
- R7: In software mode, a write with wr_en_i=1 is ignored while either flag of that channel is set. Once both flags are cleared, the same write turns the channel on.
- R8: A high oc_i bit sets the matching oc_flag_o bit, and a high lu_i bit sets the matching lu_flag_o bit. This happens in both modes, and the flags stay set after the input falls.
- R9: A 1 on a clr_oc_i or clr_lu_i bit clears the matching flag at the next edge. If the trip input is high in the same cycle as the clear, the flag stays set.
- R10: A write loads wr_vcode_i (5 bits) into channel wr_ch_i's 4-bit vcode_o field at bit offset 4*channel. Values above 15 saturate to 15.
- R11: A write changes only the vcode_o field of the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_mode_i | input | 1 | Strap: 1 automatic power-on and recovery, 0 software-gated |
| wr_valid_i | input | 1 | Channel register write strobe |
| wr_ch_i | input | 2 | Channel index for the write |
| wr_en_i | input | 1 | Enable bit to write |
| wr_vcode_i | input | 5 | Setpoint code to write, saturated to 4 bits |
| oc_i | input | 4 | Over-current comparator flags, one per channel |
| lu_i | input | 4 | Latch-up comparator flags, one per channel |
| clr_oc_i | input | 4 | Write-one-to-clear for the over-current flags |
| clr_lu_i | input | 4 | Write-one-to-clear for the latch-up flags |
| pwr_en_o | output | 4 | Supply enable, one per channel |
| vcode_o | output | 16 | Setpoint codes, 4 bits per channel |
| oc_flag_o | output | 4 | Sticky over-current status |
| lu_flag_o | output | 4 | Sticky latch-up status |
| retry_o | output | 16 | Automatic recovery counts, 4 bits per channel |

## Verification
All 32 write values are swept into every channel. This separates a correct saturation from a wrap or a truncation, and the untouched channels show whether the address decode leaks. Enable writes are walked through the channels one at a time, with over-current and latch-up trips on separate channels. Clears are applied both alone and together with an active trip, which tells the sticky-set priority apart from a plain clear. In automatic mode the hold-off window is measured at its last low cycle and its first high cycle. A second trip placed mid-window shows whether the window restarts. A run of repeated trips drives the retry counter past its saturation point.

// File: rtl/supply_enable_pkg.sv
package supply_enable_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CFG_W    = 5;
  localparam int unsigned RETRY_W  = 4;
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;
  localparam int unsigned CODE_MID = 1 << (CODE_W - 1);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CFG_W-1:0]  cfg_t;

  typedef struct packed {
    logic oc;
    logic lu;
  } trip_t;

  function automatic code_t sat_code(input cfg_t v);
    if (v > cfg_t'(CODE_MAX)) return code_t'(CODE_MAX);
    return code_t'(v);
  endfunction
endpackage

// File: rtl/supply_holdoff.sv
module supply_holdoff #(
  parameter int unsigned HOLD = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(HOLD);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  // last low cycle of the window; a reload takes priority
  assign done_o = (cnt_q == CNT_W'(1)) && !load_i;
endmodule

// File: rtl/supply_chan.sv
module supply_chan
  import supply_enable_pkg::*;
#(
  parameter int unsigned HOLD = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               auto_i,
  input  logic               wr_hit_i,
  input  logic               wr_en_i,
  input  code_t              wr_code_i,
  input  trip_t              trip_i,
  input  trip_t              clr_i,
  output logic               pwr_o,
  output code_t              code_o,
  output trip_t              flag_o,
  output logic [RETRY_W-1:0] retry_o
);
  logic               pwr_q;
  code_t              code_q;
  trip_t              flag_q;
  logic [RETRY_W-1:0] retry_q;
  logic               any_trip, busy, done;

  assign any_trip = trip_i.oc | trip_i.lu;

  supply_holdoff #(.HOLD(HOLD)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (auto_i && any_trip),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= 1'b0;
      retry_q <= '0;
    end else if (auto_i) begin
      if (any_trip) begin
        pwr_q <= 1'b0;
      end else if (done) begin
        pwr_q <= 1'b1;
        if (retry_q != '1) retry_q <= retry_q + RETRY_W'(1);
      end else if (!busy && !pwr_q) begin
        pwr_q <= 1'b1;  // power-up without command
      end
    end else begin
      if (any_trip)      pwr_q <= 1'b0;
      else if (wr_hit_i) pwr_q <= wr_en_i && !(flag_q.oc || flag_q.lu);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= code_t'(CODE_MID);
    else if (wr_hit_i) code_q <= wr_code_i;
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      flag_q.oc <= trip_i.oc | (flag_q.oc & ~clr_i.oc);
      flag_q.lu <= trip_i.lu | (flag_q.lu & ~clr_i.lu);
    end
  end

  assign pwr_o   = pwr_q;
  assign code_o  = code_q;
  assign flag_o  = flag_q;
  assign retry_o = retry_q;
endmodule

// File: rtl/supply_enable_ctrl.sv
module supply_enable_ctrl
  import supply_enable_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned HOLD   = 1024,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        auto_mode_i,
  input  logic                        wr_valid_i,
  input  logic [CH_W-1:0]             wr_ch_i,
  input  logic                        wr_en_i,
  input  logic [CFG_W-1:0]            wr_vcode_i,
  input  logic [NUM_CH-1:0]           oc_i,
  input  logic [NUM_CH-1:0]           lu_i,
  input  logic [NUM_CH-1:0]           clr_oc_i,
  input  logic [NUM_CH-1:0]           clr_lu_i,
  output logic [NUM_CH-1:0]           pwr_en_o,
  output logic [NUM_CH*CODE_W-1:0]    vcode_o,
  output logic [NUM_CH-1:0]           oc_flag_o,
  output logic [NUM_CH-1:0]           lu_flag_o,
  output logic [NUM_CH*RETRY_W-1:0]   retry_o
);
  code_t wr_code;
  assign wr_code = sat_code(wr_vcode_i);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    trip_t trip, clr, flag;
    logic  hit;

    assign hit  = wr_valid_i && (wr_ch_i == CH_W'(i));
    assign trip = '{oc: oc_i[i], lu: lu_i[i]};
    assign clr  = '{oc: clr_oc_i[i], lu: clr_lu_i[i]};

    supply_chan #(.HOLD(HOLD)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .auto_i    (auto_mode_i),
      .wr_hit_i  (hit),
      .wr_en_i   (wr_en_i),
      .wr_code_i (wr_code),
      .trip_i    (trip),
      .clr_i     (clr),
      .pwr_o     (pwr_en_o[i]),
      .code_o    (vcode_o[i*CODE_W +: CODE_W]),
      .flag_o    (flag),
      .retry_o   (retry_o[i*RETRY_W +: RETRY_W])
    );

    assign oc_flag_o[i] = flag.oc;
    assign lu_flag_o[i] = flag.lu;
  end
endmodule

// File: rtl/supply_enable_chk.sv
module supply_enable_chk
  import supply_enable_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      auto_mode_i,
  input logic                      wr_valid_i,
  input logic [NUM_CH-1:0]         oc_i,
  input logic [NUM_CH-1:0]         lu_i,
  input logic [NUM_CH-1:0]         clr_oc_i,
  input logic [NUM_CH-1:0]         clr_lu_i,
  input logic [NUM_CH-1:0]         pwr_en_o,
  input logic [NUM_CH*CODE_W-1:0]  vcode_o,
  input logic [NUM_CH-1:0]         oc_flag_o,
  input logic [NUM_CH-1:0]         lu_flag_o,
  input logic [NUM_CH*RETRY_W-1:0] retry_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R6
  trip_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && ((oc_i | lu_i) != '0) |=> ((pwr_en_o & $past(oc_i | lu_i)) == '0));

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> (((oc_flag_o & $past(oc_i)) == $past(oc_i)) &&
                   ((lu_flag_o & $past(lu_i)) == $past(lu_i))));

  // R9
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && (clr_oc_i == '0) && (clr_lu_i == '0) |=>
      (((oc_flag_o & $past(oc_flag_o)) == $past(oc_flag_o)) &&
       ((lu_flag_o & $past(lu_flag_o)) == $past(lu_flag_o))));

  // R11
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !wr_valid_i |=> $stable(vcode_o));

  // R2
  retry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !auto_mode_i |=> $stable(retry_o));

  // R5
  sw_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !auto_mode_i && !wr_valid_i |=> ((pwr_en_o & ~$past(pwr_en_o)) == '0));
endmodule

bind supply_enable_ctrl supply_enable_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .auto_mode_i (auto_mode_i),
  .wr_valid_i  (wr_valid_i),
  .oc_i        (oc_i),
  .lu_i        (lu_i),
  .clr_oc_i    (clr_oc_i),
  .clr_lu_i    (clr_lu_i),
  .pwr_en_o    (pwr_en_o),
  .vcode_o     (vcode_o),
  .oc_flag_o   (oc_flag_o),
  .lu_flag_o   (lu_flag_o),
  .retry_o     (retry_o)
);

// File: tb/supply_enable_ctrl_test.sv
`timescale 1ns/1ps
module supply_enable_ctrl_test;
  localparam int NCH  = 4;
  localparam int HOLD = 1024;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          auto_mode = 1'b0;
  logic          wr_valid = 1'b0;
  logic [1:0]    wr_ch = '0;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_vcode = '0;
  logic [NCH-1:0] oc = '0, lu = '0, clr_oc = '0, clr_lu = '0;
  logic [NCH-1:0] pwr_en, oc_flag, lu_flag;
  logic [NCH*4-1:0] vcode, retry;

  int checks = 0, errors = 0;
  int exp_code [NCH];
  logic [NCH-1:0] exp_en;

  always #2 clk = ~clk;

  supply_enable_ctrl #(.NUM_CH(NCH), .HOLD(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .auto_mode_i(auto_mode),
    .wr_valid_i(wr_valid), .wr_ch_i(wr_ch), .wr_en_i(wr_en), .wr_vcode_i(wr_vcode),
    .oc_i(oc), .lu_i(lu), .clr_oc_i(clr_oc), .clr_lu_i(clr_lu),
    .pwr_en_o(pwr_en), .vcode_o(vcode), .oc_flag_o(oc_flag), .lu_flag_o(lu_flag),
    .retry_o(retry)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_write(input int ch, input bit en, input int code);
    wr_valid = 1'b1; wr_ch = 2'(ch); wr_en = en; wr_vcode = 5'(code);
    step();
    wr_valid = 1'b0;
  endtask

  task automatic do_reset(input bit mode);
    rst_ni = 1'b0; auto_mode = mode;
    step(2);
    check(pwr_en == '0, "R1 pwr in reset", int'(pwr_en), 0);
    check(oc_flag == '0 && lu_flag == '0, "R1 flags", int'({oc_flag, lu_flag}), 0);
    check(retry == '0, "R1 retry", int'(retry), 0);
    for (int c = 0; c < NCH; c++) begin
      check(vcode[c*4 +: 4] == 4'd8, "R1 vcode mid", int'(vcode[c*4 +: 4]), 8);
      exp_code[c] = 8;
    end
    rst_ni = 1'b1;
    #0.5;
    check(pwr_en == '0, "R1 pwr after release", int'(pwr_en), 0);
    step();
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // ---------------- software mode ----------------
    step();
    do_reset(1'b0);
    exp_en = '0;
    check(pwr_en == '0, "R5 off without write", int'(pwr_en), 0);
    for (int c = 0; c < NCH; c++) begin
      do_write(c, 1'b1, 8);
      exp_en[c] = 1'b1;
      check(pwr_en == exp_en, "R5 walk enable", int'(pwr_en), int'(exp_en));
    end
    do_write(1, 1'b0, 8);
    exp_en[1] = 1'b0;
    check(pwr_en == exp_en, "R5 disable ch1", int'(pwr_en), int'(exp_en));

    // R10 / R11 code sweep
    for (int c = 0; c < NCH; c++) begin
      for (int v = 0; v < 32; v++) begin
        do_write(c, exp_en[c], v);
        exp_code[c] = (v > 15) ? 15 : v;
        for (int o = 0; o < NCH; o++)
          check(vcode[o*4 +: 4] == 4'(exp_code[o]), (o == c) ? "R10 saturate" : "R11 others",
                int'(vcode[o*4 +: 4]), exp_code[o]);
      end
    end
    check(pwr_en == exp_en, "R5 enables kept over code writes", int'(pwr_en), int'(exp_en));

    // R6 / R8 trips
    oc[2] = 1'b1; lu[3] = 1'b1;
    step();
    oc = '0; lu = '0;
    exp_en[2] = 1'b0; exp_en[3] = 1'b0;
    check(pwr_en == exp_en, "R6 trip clears enable", int'(pwr_en), int'(exp_en));
    check(oc_flag == 4'b0100, "R8 oc flag", int'(oc_flag), 4);
    check(lu_flag == 4'b1000, "R8 lu flag", int'(lu_flag), 8);
    step(5);
    check(pwr_en == exp_en, "R6 stays off", int'(pwr_en), int'(exp_en));
    check(oc_flag == 4'b0100 && lu_flag == 4'b1000, "R8 sticky", int'({oc_flag, lu_flag}), 8'h48);

    // R7 blocked re-enable
    do_write(2, 1'b1, 3);
    check(pwr_en[2] == 1'b0, "R7 write blocked by flag", int'(pwr_en[2]), 0);

    // R9 set wins over clear
    oc[2] = 1'b1; clr_oc[2] = 1'b1;
    step();
    oc = '0;
    check(oc_flag[2] == 1'b1, "R9 set beats clear", int'(oc_flag[2]), 1);
    step();
    clr_oc = '0;
    check(oc_flag[2] == 1'b0, "R9 clear", int'(oc_flag[2]), 0);
    clr_lu[3] = 1'b1;
    step();
    clr_lu = '0;
    check(lu_flag == '0, "R9 clear lu", int'(lu_flag), 0);
    do_write(2, 1'b1, 3);
    exp_en[2] = 1'b1;
    check(pwr_en == exp_en, "R7 enable after clear", int'(pwr_en), int'(exp_en));

    // ---------------- automatic mode ----------------
    do_reset(1'b1);
    check(pwr_en == 4'hF, "R2 auto power-up", int'(pwr_en), 15);
    do_write(0, 1'b0, 2);
    check(pwr_en == 4'hF, "R2 write enable ignored", int'(pwr_en), 15);

    // R3 window
    oc[0] = 1'b1;
    step();
    oc = '0;
    check(pwr_en[0] == 1'b0, "R3 off after trip", int'(pwr_en[0]), 0);
    check(oc_flag[0] == 1'b1, "R8 auto flag", int'(oc_flag[0]), 1);
    step(HOLD - 1);
    check(pwr_en[0] == 1'b0, "R3 last low cycle", int'(pwr_en[0]), 0);
    check(retry[3:0] == 4'd0, "R3 retry before", int'(retry[3:0]), 0);
    step();
    check(pwr_en[0] == 1'b1, "R3 recovered", int'(pwr_en[0]), 1);
    check(retry[3:0] == 4'd1, "R3 retry count", int'(retry[3:0]), 1);

    // R4 restart inside window
    lu[1] = 1'b1;
    step();
    lu = '0;
    step(500);
    lu[1] = 1'b1;
    step();
    lu = '0;
    step(HOLD - 1);
    check(pwr_en[1] == 1'b0, "R4 window restarted", int'(pwr_en[1]), 0);
    step();
    check(pwr_en[1] == 1'b1, "R4 recovered", int'(pwr_en[1]), 1);
    check(retry[7:4] == 4'd1, "R4 single count", int'(retry[7:4]), 1);

    // R4 saturation
    for (int t = 0; t < 17; t++) begin
      oc[3] = 1'b1;
      step();
      oc = '0;
      step(HOLD);
    end
    check(retry[15:12] == 4'd15, "R4 retry saturates", int'(retry[15:12]), 15);
    check(pwr_en == 4'hF, "R3 all on at end", int'(pwr_en), 15);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule